// File: doc/BRIEF.md
# Compare Unit with Self-Disarming Channels

A bank of compare channels watches one shared free-running timer value. Each channel holds its own compare value and a small mode field. When the timer equals the compare value and the channel's mode allows compare, the channel raises a one-cycle event pulse. A channel can also be put into single-event operation. In that case it fires only while its bit in a shared arm register is 1, and hardware clears that bit on the match. Any later match on that channel is then suppressed until software arms it again.

The arm register is shared by all channels. Software that reads it, changes one bit and writes the whole word back can restore a bit that hardware cleared in the meantime, which arms an unwanted second event. To avoid this, the block also has a set-mask port and a clear-mask port. Each of these touches only the bits written as 1. A hardware clear always wins over any software write to the same bit in the same cycle. The mode field is only ever changed by software.

Register map (5-bit word address, 16-bit data): addresses 0..7 hold the compare value of channels 0..7, and addresses 8..15 hold the mode of channels 0..7. Address 16 is the arm register, written as a whole word. Address 17 is the set-mask port and address 18 is the clear-mask port. Reads of 16, 17 and 18 all return the arm register. In the mode field, bit 0 enables compare and bit 1 selects single-event operation.

Top module: `cmpu_top`

## Requirements
- R1: After reset every compare value, every mode field and the arm register read 0, and all event outputs are 0.
- R2: A channel whose mode bit 0 is 1 and mode bit 1 is 0 drives its event bit high for the one cycle after each clock edge at which the timer equals its compare value. It fires again at every matching edge, and several channels may fire together.
- R3: A channel whose mode bit 0 is 0 never produces an event, whatever its other bits or the timer value, and its arm bit stays unchanged.
- R4: A channel with mode bits 1 and 0 both set and its arm bit at 1 produces an event on a match, and the same clock edge clears its arm bit.
- R5: A channel in single-event operation whose arm bit is 0 produces no event on a match.
- R6: A write to address 16 replaces the whole arm register with the low 8 data bits.
- R7: A write to address 17 sets every arm bit whose data bit is 1 and leaves the others unchanged.
- R8: A write to address 18 clears every arm bit whose data bit is 1 and leaves the others unchanged.
- R9: When a hardware clear and a software write (whole word or set-mask) hit the same arm bit at the same clock edge, the bit ends at 0. The other bits take the written result.
- R10: Mode fields change only through writes to addresses 8..15, never through an event.
- R11: Compare values and mode fields read back as last written, at their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| timer_i | input | 16 | Shared timer value |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| event_o | output | 8 | One-cycle event pulse per channel |

## Verification
If the arm register holds a wrong bit, the fault shows at the ports on the next matching timer value. A bit that should have been cleared gives a second event on a single-event channel, and a bit lost to a software write gives a missing event. Either is visible one cycle after the match edge, and at once in the arm register readback. The race cases drive a match and a software write at the same edge, so a wrong priority shows in the readback right after that edge. A mode field changed by hardware shows in its readback after any event.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  localparam int MODE_W  = 2;
  localparam int MB_CMP  = 0;
  localparam int MB_ONCE = 1;
endpackage

// File: rtl/cmpu_chan.sv
module cmpu_chan
  import cmpu_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_we,
  input  logic              mode_we,
  input  logic [TW-1:0]     cmp_wd,
  input  logic [MODE_W-1:0] mode_wd,
  input  logic [TW-1:0]     timer,
  input  logic              armed,
  output logic [TW-1:0]     cmp_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              hw_clr,
  output logic              evt_q
);
  logic [TW-1:0]     cmp_r, cmp_d;
  logic [MODE_W-1:0] mode_r, mode_d;
  logic              evt_r, evt_d;
  logic              hit;

  always_comb begin
    cmp_d = cmp_r;
    if (cmp_we) cmp_d = cmp_wd;
    mode_d = mode_r;
    if (mode_we) mode_d = mode_wd;
    hit    = (timer == cmp_r) && mode_r[MB_CMP] && (!mode_r[MB_ONCE] || armed);
    hw_clr = hit && mode_r[MB_ONCE];
    evt_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_r  <= '0;
      mode_r <= '0;
      evt_r  <= 1'b0;
    end else begin
      cmp_r  <= cmp_d;
      mode_r <= mode_d;
      evt_r  <= evt_d;
    end
  end

  assign cmp_q  = cmp_r;
  assign mode_q = mode_r;
  assign evt_q  = evt_r;
endmodule

// File: rtl/cmpu_arm.sv
module cmpu_arm #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_we,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [N_CH-1:0] wd,
  input  logic [N_CH-1:0] hw_clr,
  output logic [N_CH-1:0] arm_q
);
  logic [N_CH-1:0] arm_r, arm_d, sw_d;

  always_comb begin
    sw_d = arm_r;
    if (word_we)     sw_d = wd;
    else if (set_we) sw_d = arm_r | wd;
    else if (clr_we) sw_d = arm_r & ~wd;
    arm_d = sw_d & ~hw_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_r <= '0;
    else        arm_r <= arm_d;
  end

  assign arm_q = arm_r;
endmodule

// File: rtl/cmpu_regif.sv
module cmpu_regif
  import cmpu_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int TW   = 16,
  parameter int DW   = 16,
  parameter int AW   = 5
) (
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [N_CH*TW-1:0]     cmp_flat,
  input  logic [N_CH*MODE_W-1:0] mode_flat,
  input  logic [N_CH-1:0]        arm,
  output logic [N_CH-1:0]        cmp_we,
  output logic [N_CH-1:0]        mode_we,
  output logic                   word_we,
  output logic                   set_we,
  output logic                   clr_we,
  output logic [DW-1:0]          rdata
);
  localparam logic [AW-1:0] A_WORD = AW'(2*N_CH);
  localparam logic [AW-1:0] A_SET  = AW'(2*N_CH+1);
  localparam logic [AW-1:0] A_CLR  = AW'(2*N_CH+2);

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      cmp_we[i]  = wr_en && (addr == AW'(i));
      mode_we[i] = wr_en && (addr == AW'(N_CH+i));
    end
    word_we = wr_en && (addr == A_WORD);
    set_we  = wr_en && (addr == A_SET);
    clr_we  = wr_en && (addr == A_CLR);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (addr == AW'(i))      rdata = DW'(cmp_flat[i*TW +: TW]);
      if (addr == AW'(N_CH+i)) rdata = DW'(mode_flat[i*MODE_W +: MODE_W]);
    end
    if (addr == A_WORD || addr == A_SET || addr == A_CLR) rdata = DW'(arm);
  end
endmodule

// File: rtl/cmpu_top.sv
module cmpu_top
  import cmpu_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int TW   = 16,
  parameter int DW   = 16,
  localparam int AW  = $clog2(2*N_CH+3)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TW-1:0]   timer_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N_CH-1:0] event_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [N_CH*TW-1:0]     cmp_flat;
  logic [N_CH*MODE_W-1:0] mode_flat;
  logic [N_CH-1:0]        se_en, hw_clr, cmp_we, mode_we;
  logic                   word_we, set_we, clr_we;

  cmpu_regif #(.N_CH(N_CH), .TW(TW), .DW(DW), .AW(AW)) regif_i (
    .wr_en(wr_en_i), .addr(addr_i), .cmp_flat(cmp_flat), .mode_flat(mode_flat),
    .arm(se_en), .cmp_we(cmp_we), .mode_we(mode_we), .word_we(word_we),
    .set_we(set_we), .clr_we(clr_we), .rdata(rdata_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    cmpu_chan #(.TW(TW)) chan_i (
      .clk(clk_i), .rst_n(rst_sync_n), .cmp_we(cmp_we[g]), .mode_we(mode_we[g]),
      .cmp_wd(wdata_i[TW-1:0]), .mode_wd(wdata_i[MODE_W-1:0]), .timer(timer_i),
      .armed(se_en[g]), .cmp_q(cmp_flat[g*TW +: TW]),
      .mode_q(mode_flat[g*MODE_W +: MODE_W]), .hw_clr(hw_clr[g]), .evt_q(event_o[g])
    );
  end

  cmpu_arm #(.N_CH(N_CH)) arm_i (
    .clk(clk_i), .rst_n(rst_sync_n), .word_we(word_we), .set_we(set_we),
    .clr_we(clr_we), .wd(wdata_i[N_CH-1:0]), .hw_clr(hw_clr), .arm_q(se_en)
  );
endmodule

// File: rtl/cmpu_checker.sv
module cmpu_checker #(
  parameter int N_CH   = 8,
  parameter int TW     = 16,
  parameter int MODE_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [TW-1:0]          timer,
  input logic                   wr_en,
  input logic [N_CH*TW-1:0]     cmp_flat,
  input logic [N_CH*MODE_W-1:0] mode_flat,
  input logic [N_CH-1:0]        se_en,
  input logic [N_CH-1:0]        evt
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    p_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |-> $past(timer) == $past(cmp_flat[i*TW +: TW]))
      else $error("R2 event without match on channel %0d", i);
    p_cmp_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |-> $past(mode_flat[i*MODE_W]))
      else $error("R3 event with compare disabled on channel %0d", i);
    p_autoclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && $past(mode_flat[i*MODE_W+1])) |-> !se_en[i])
      else $error("R4 arm bit not cleared on channel %0d", i);
    p_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && $past(mode_flat[i*MODE_W+1])) |-> $past(se_en[i]))
      else $error("R5 event while disarmed on channel %0d", i);
  end

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(mode_flat))
    else $error("R10 mode changed without a write");
endmodule

bind cmpu_top cmpu_checker #(.N_CH(N_CH), .TW(TW), .MODE_W(cmpu_pkg::MODE_W)) chk_i (
  .clk(clk_i), .rst_n(rst_sync_n), .timer(timer_i), .wr_en(wr_en_i),
  .cmp_flat(cmp_flat), .mode_flat(mode_flat), .se_en(se_en), .evt(event_o)
);

// File: tb/cmpu_top_tb_top.sv
`timescale 1ns/1ps
module cmpu_top_tb_top;
  localparam logic [15:0] IDLE = 16'hFFFF;
  localparam logic [4:0] A_WORD = 5'd16, A_SET = 5'd17, A_CLR = 5'd18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timer = IDLE;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  event_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmpu_top dut_i (.clk_i(clk), .rst_ni(rst_n), .timer_i(timer), .wr_en_i(wr_en),
                  .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .event_o(event_o));

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic step(input logic [15:0] t, output logic [7:0] ev);
    @(negedge clk); timer = t;
    @(negedge clk); ev = event_o; timer = IDLE;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1", "events", {8'h0, event_o}, 16'h0);
    rd(5'd0, d);  chk("R1", "cmp0", d, 16'h0);
    rd(5'd8, d);  chk("R1", "mode0", d, 16'h0);
    rd(A_WORD, d); chk("R1", "arm", d, 16'h0);
  endtask

  task automatic t_continuous;
    logic [15:0] d; logic [7:0] ev, ev2;
    wr(5'd2, 16'h1234); wr(5'd10, 16'h0001);
    rd(5'd2, d);  chk("R11", "cmp2 readback", d, 16'h1234);
    rd(5'd10, d); chk("R11", "mode2 readback", d, 16'h0001);
    step(16'h1234, ev); chk("R2", "single match", {8'h0, ev}, 16'h0004);
    @(negedge clk); timer = 16'h1234;
    @(negedge clk); ev = event_o;
    @(negedge clk); ev2 = event_o; timer = IDLE;
    chk("R2", "held match 1", {8'h0, ev}, 16'h0004);
    chk("R2", "held match 2", {8'h0, ev2}, 16'h0004);
    step(16'h1235, ev); chk("R2", "no match", {8'h0, ev}, 16'h0);
    wr(5'd6, 16'h1234); wr(5'd14, 16'h0001);
    step(16'h1234, ev); chk("R2", "two channels", {8'h0, ev}, 16'h0044);
  endtask

  task automatic t_disabled;
    logic [15:0] d; logic [7:0] ev;
    wr(5'd3, 16'h0055);
    step(16'h0055, ev); chk("R3", "mode off", {8'h0, ev}, 16'h0);
    wr(5'd11, 16'h0002); wr(A_WORD, 16'h0008);
    step(16'h0055, ev); chk("R3", "single without compare", {8'h0, ev}, 16'h0);
    rd(A_WORD, d); chk("R3", "arm untouched", d, 16'h0008);
  endtask

  task automatic t_single;
    logic [15:0] d; logic [7:0] ev;
    wr(A_WORD, 16'h0020);
    rd(A_WORD, d); chk("R6", "word write", d, 16'h0020);
    wr(5'd5, 16'h0AAA); wr(5'd13, 16'h0003);
    step(16'h0AAA, ev); chk("R4", "armed fires", {8'h0, ev}, 16'h0020);
    rd(A_WORD, d); chk("R4", "arm auto-cleared", d, 16'h0000);
    rd(5'd13, d);  chk("R10", "mode kept", d, 16'h0003);
    step(16'h0AAA, ev); chk("R5", "disarmed silent", {8'h0, ev}, 16'h0);
  endtask

  task automatic t_masks;
    logic [15:0] d;
    wr(A_WORD, 16'h000F);
    wr(A_SET, 16'h0030);
    rd(A_SET, d); chk("R7", "set mask", d, 16'h003F);
    wr(A_CLR, 16'h0005);
    rd(A_CLR, d); chk("R8", "clear mask", d, 16'h003A);
  endtask

  task automatic t_race;
    logic [15:0] d; logic [7:0] ev;
    @(negedge clk); timer = 16'h0AAA; wr_en = 1'b1; addr = A_SET; wdata = 16'h0041;
    @(negedge clk); ev = event_o; wr_en = 1'b0; timer = IDLE;
    chk("R9", "event with set race", {8'h0, ev}, 16'h0020);
    rd(A_WORD, d); chk("R9", "clear beats set", d, 16'h005B);
    wr(A_SET, 16'h0020);
    @(negedge clk); timer = 16'h0AAA; wr_en = 1'b1; addr = A_WORD; wdata = 16'h00FF;
    @(negedge clk); ev = event_o; wr_en = 1'b0; timer = IDLE;
    chk("R9", "event with word race", {8'h0, ev}, 16'h0020);
    rd(A_WORD, d); chk("R9", "clear beats word", d, 16'h00DF);
    rd(5'd13, d);  chk("R10", "mode after race", d, 16'h0003);
    wr(5'd7, 16'hBEEF);
    rd(5'd7, d);   chk("R11", "cmp7 readback", d, 16'hBEEF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_continuous;
    t_disabled;
    t_single;
    t_masks;
    t_race;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule